// File: doc/BRIEF.md
# CAN Receive Overflow Guard

This block sits between the bit-stream side of a CAN receiver and the write port of a message RAM. The receiver hands it the bytes of each frame and single-cycle markers for the frame's phases: start of frame, end of the arbitration field, start of the CRC field, start of the seventh end-of-frame bit, and a frame error. The guard collects the bytes of the frame on the bus in a staging buffer. At the start of the CRC field it moves them into a save buffer. From the save buffer it writes them to RAM through a valid/ready handshake. It adds the frame to a receive FIFO only once the frame is valid, which is at the seventh end-of-frame bit.

Saving the older frame can fall behind because the RAM does not accept writes, and the next frame can then reach its own deadline. When that happens the guard discards the newer frame and finishes the older one, so the older frame is still stored completely. It also raises a system-error flag with a fixed interrupt code. Software clears that flag by writing zero to it. When the FIFO is already full at the moment a frame becomes valid, the guard drops the frame and pulses a separate full indication instead of raising the system error. Frames that arrive later are received normally in all cases.

Top module: `can_rx_overflow_guard`

## Requirements
- R1: Bytes of an accepted frame are written to RAM in arrival order. The RAM address is slot × MAX_BYTES + byte index, where the slot is the FIFO write slot. Copying starts in the cycle after the CRC-start marker. A write that is not accepted is held with the same address and data.
- R2: The FIFO entry count does not rise before the seventh end-of-frame bit. It rises by one, one cycle after both that bit has been seen and all bytes of the frame have been written.
- R3: If a save has not yet committed when the next frame's arbitration-end marker (or its CRC-start marker) arrives, the newer frame is discarded. None of its bytes are written and it never gets a FIFO entry.
- R4: After an overflow, the older frame still writes all of its bytes and commits one FIFO entry.
- R5: Once an overflow has been resolved, the next frame is copied and committed normally.
- R6: An overflow sets `serr_flag` in the next cycle. `int_code` reads 7'b1000101 while the flag is set and 7'b0000000 otherwise.
- R7: A flag write with data 0 clears `serr_flag`, and `int_code` returns to zero. A flag write with data 1 has no effect.
- R8: A frame error before the seventh end-of-frame bit abandons the frame and the FIFO count is not changed. An error before the CRC start also prevents every RAM write of that frame.
- R9: If the FIFO holds DEPTH entries when a frame's seventh end-of-frame bit arrives, the frame is dropped. `full_drop` pulses for one cycle, the count stays at DEPTH and `serr_flag` is not set. While the FIFO is full, writes for a frame that is not yet valid are held back.
- R10: A pop on a non-empty FIFO lowers the count by one and advances `fifo_rd_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Start-of-frame marker |
| rx_arb_end | input | 1 | End of the arbitration field |
| rx_crc_start | input | 1 | Start of the CRC field |
| rx_eof7 | input | 1 | Start of the seventh end-of-frame bit |
| rx_err | input | 1 | Frame error on the bus |
| rx_byte_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| ram_wvalid | output | 1 | RAM write request |
| ram_wready | input | 1 | RAM write accepted |
| ram_waddr | output | SW+BW | RAM byte address |
| ram_wdata | output | 8 | RAM write byte |
| fifo_pop | input | 1 | Reader releases the oldest entry |
| fifo_count | output | SW+1 | Committed entries |
| fifo_rd_slot | output | SW | Slot of the oldest entry |
| full_drop | output | 1 | Frame dropped because the FIFO was full |
| serr_wr | input | 1 | Write strobe for the system-error flag |
| serr_wdata | input | 1 | Value written to the flag |
| serr_flag | output | 1 | System-error flag |
| int_code | output | 7 | Interrupt code |

## Verification
The bench tries the guard with several kinds of traffic. Clean back-to-back frames with an always-ready RAM check byte order and the commit point. Frames with an error before or after the CRC start separate abandoning a frame before copying from abandoning it during copying. A RAM that stalls across the next frame's arbitration end shows that the newer frame is dropped while the older one completes. Filling the FIFO without pops separates a full drop from a system-error overflow. Flag writes of one and of zero show which one clears.

// File: rtl/can_rx_overflow_guard.sv
module can_rx_overflow_guard #(
  parameter int MAX_BYTES = 8,
  parameter int DEPTH = 4,
  localparam int BW = $clog2(MAX_BYTES),
  localparam int SW = $clog2(DEPTH),
  localparam int AW = SW + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_sof,
  input  logic          rx_arb_end,
  input  logic          rx_crc_start,
  input  logic          rx_eof7,
  input  logic          rx_err,
  input  logic          rx_byte_vld,
  input  logic [7:0]    rx_byte,
  output logic          ram_wvalid,
  input  logic          ram_wready,
  output logic [AW-1:0] ram_waddr,
  output logic [7:0]    ram_wdata,
  input  logic          fifo_pop,
  output logic [SW:0]   fifo_count,
  output logic [SW-1:0] fifo_rd_slot,
  output logic          full_drop,
  input  logic          serr_wr,
  input  logic          serr_wdata,
  output logic          serr_flag,
  output logic [6:0]    int_code
);
  localparam logic [6:0] SERR_CODE = 7'b1000101;
  localparam logic [BW:0] LEN_MAX = (BW+1)'(MAX_BYTES);
  localparam logic [SW:0] CNT_FULL = (SW+1)'(DEPTH);

  logic [7:0]    stage [MAX_BYTES];
  logic [7:0]    save  [MAX_BYTES];
  logic [BW:0]   st_len, sv_len, sv_idx;
  logic          rx_skip, sv_act, sv_eof;
  logic [SW-1:0] wptr, rptr;
  logic [SW:0]   cnt;

  wire full    = (cnt == CNT_FULL);
  wire late    = sv_act && (rx_arb_end || rx_crc_start) && !rx_skip;
  wire handoff = rx_crc_start && !rx_skip && !sv_act && !rx_err;
  wire commit  = sv_act && sv_eof && (sv_idx == sv_len);
  wire abort   = rx_err && sv_act && !sv_eof;
  wire eof_hit = rx_eof7 && sv_act && !sv_eof && !rx_err;
  wire pop     = fifo_pop && (cnt != '0);

  assign ram_wvalid   = sv_act && (sv_idx < sv_len) && (sv_eof || !full);
  assign ram_waddr    = {wptr, sv_idx[BW-1:0]};
  assign ram_wdata    = save[sv_idx[BW-1:0]];
  assign fifo_count   = cnt;
  assign fifo_rd_slot = rptr;
  assign int_code     = serr_flag ? SERR_CODE : 7'b0000000;

  always_ff @(posedge clk) begin
    if (rx_byte_vld && !rx_sof && !rx_skip && st_len < LEN_MAX)
      stage[st_len[BW-1:0]] <= rx_byte;
    if (handoff)
      for (int i = 0; i < MAX_BYTES; i++) save[i] <= stage[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_len  <= '0;
      rx_skip <= 1'b0;
    end else if (rx_sof) begin
      st_len  <= '0;
      rx_skip <= 1'b0;
    end else begin
      if (rx_byte_vld && !rx_skip && st_len < LEN_MAX) st_len <= st_len + 1'b1;
      if (late || rx_err) rx_skip <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_act    <= 1'b0;
      sv_eof    <= 1'b0;
      sv_len    <= '0;
      sv_idx    <= '0;
      full_drop <= 1'b0;
    end else begin
      full_drop <= eof_hit && full;
      if (ram_wvalid && ram_wready) sv_idx <= sv_idx + 1'b1;
      if (handoff) begin
        sv_act <= 1'b1;
        sv_eof <= 1'b0;
        sv_len <= st_len;
        sv_idx <= '0;
      end else if (abort) begin
        sv_act <= 1'b0;
      end else if (eof_hit) begin
        if (full) sv_act <= 1'b0;
        else      sv_eof <= 1'b1;
      end else if (commit) begin
        sv_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr + SW'(commit);
      rptr <= rptr + SW'(pop);
      cnt  <= cnt + (SW+1)'(commit) - (SW+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      serr_flag <= 1'b0;
    else if (late)                   serr_flag <= 1'b1;
    else if (serr_wr && !serr_wdata) serr_flag <= 1'b0;
  end
endmodule

// File: rtl/can_rx_overflow_guard_chk.sv
module can_rx_overflow_guard_chk #(
  parameter int DEPTH = 4,
  parameter int AW = 5,
  localparam int SW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_arb_end,
  input logic          rx_crc_start,
  input logic          rx_err,
  input logic          ram_wvalid,
  input logic          ram_wready,
  input logic [AW-1:0] ram_waddr,
  input logic [7:0]    ram_wdata,
  input logic          fifo_pop,
  input logic [SW:0]   fifo_count,
  input logic          full_drop,
  input logic          serr_wr,
  input logic          serr_wdata,
  input logic          serr_flag
);
  p_write_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wvalid && !ram_wready && !rx_err) |=>
      (ram_wvalid && $stable(ram_waddr) && $stable(ram_wdata)));

  p_count_no_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_pop |=> (fifo_count >= $past(fifo_count)));

  p_flag_from_deadline_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serr_flag) |-> $past(rx_arb_end || rx_crc_start));

  p_zero_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_wr && !serr_wdata && !rx_arb_end && !rx_crc_start) |=> !serr_flag);

  p_drop_only_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full_drop |-> ($past(fifo_count) == (SW+1)'(DEPTH)));
endmodule

bind can_rx_overflow_guard can_rx_overflow_guard_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_arb_end(rx_arb_end), .rx_crc_start(rx_crc_start),
  .rx_err(rx_err), .ram_wvalid(ram_wvalid), .ram_wready(ram_wready),
  .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .fifo_pop(fifo_pop),
  .fifo_count(fifo_count), .full_drop(full_drop), .serr_wr(serr_wr),
  .serr_wdata(serr_wdata), .serr_flag(serr_flag)
);

// File: tb/can_rx_overflow_guard_test.sv
module can_rx_overflow_guard_test;
  localparam int MB = 8;
  localparam int DP = 4;

  logic clk = 0, rst_n = 0;
  logic sof = 0, arb = 0, crc = 0, eof7 = 0, err = 0, bvld = 0;
  logic [7:0] bdat = 0;
  logic rdy = 1, pop = 0, swr = 0, swd = 0;
  logic wvalid, fdrop, serr;
  logic [4:0] waddr;
  logic [7:0] wdata;
  logic [2:0] cnt;
  logic [1:0] rslot;
  logic [6:0] code;

  always #4 clk = ~clk;

  can_rx_overflow_guard uut (
    .clk(clk), .rst_n(rst_n), .rx_sof(sof), .rx_arb_end(arb), .rx_crc_start(crc),
    .rx_eof7(eof7), .rx_err(err), .rx_byte_vld(bvld), .rx_byte(bdat),
    .ram_wvalid(wvalid), .ram_wready(rdy), .ram_waddr(waddr), .ram_wdata(wdata),
    .fifo_pop(pop), .fifo_count(cnt), .fifo_rd_slot(rslot), .full_drop(fdrop),
    .serr_wr(swr), .serr_wdata(swd), .serr_flag(serr), .int_code(code));

  int compared = 0, mismatched = 0;
  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  byte unsigned m_st[$], m_sv[$];
  bit m_skip = 0, m_sva = 0, m_sve = 0, m_serr = 0, m_fd = 0;
  int m_idx = 0, m_wp = 0, m_rp = 0, m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = {}; m_sv = {}; m_skip = 0; m_sva = 0; m_sve = 0; m_serr = 0; m_fd = 0;
      m_idx = 0; m_wp = 0; m_rp = 0; m_cnt = 0;
    end else begin
      bit full, wv, late, hand, cmt, eh, ab, pp;
      full = (m_cnt == DP);
      wv   = m_sva && m_idx < m_sv.size() && (m_sve || !full);
      late = m_sva && (arb || crc) && !m_skip;
      hand = crc && !m_skip && !m_sva && !err;
      cmt  = m_sva && m_sve && m_idx == m_sv.size();
      eh   = eof7 && m_sva && !m_sve && !err;
      ab   = err && m_sva && !m_sve;
      pp   = pop && m_cnt > 0;
      m_fd = eh && full;
      if (wv && rdy) m_idx++;
      if (hand) begin m_sv = m_st; m_idx = 0; m_sva = 1; m_sve = 0; end
      else if (ab) m_sva = 0;
      else if (eh) begin if (full) m_sva = 0; else m_sve = 1; end
      else if (cmt) m_sva = 0;
      if (sof) begin m_st = {}; m_skip = 0; end
      else begin
        if (bvld && !m_skip && m_st.size() < MB) m_st.push_back(bdat);
        if (late || err) m_skip = 1;
      end
      if (cmt) m_wp = (m_wp + 1) % DP;
      if (pp) m_rp = (m_rp + 1) % DP;
      m_cnt = m_cnt + int'(cmt) - int'(pp);
      if (late) m_serr = 1;
      else if (swr && !swd) m_serr = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit ewv;
    ewv = m_sva && m_idx < m_sv.size() && (m_sve || m_cnt != DP);
    chk("R1 wvalid", wvalid, ewv);
    if (ewv && wvalid) begin
      chk("R1 waddr", waddr, m_wp * MB + m_idx);
      chk("R1 wdata", wdata, m_sv[m_idx]);
    end
    chk("R2 fifo_count", cnt, m_cnt);
    chk("R10 rd_slot", rslot, m_rp);
    chk("R9 full_drop", fdrop, m_fd);
    chk("R6 serr_flag", serr, m_serr);
    chk("R6 int_code", code, m_serr ? 69 : 0);
  end

  // RAM image and write counter
  byte unsigned img [32];
  int nwr = 0, nfd = 0;
  always @(posedge clk) begin
    if (rst_n && wvalid && rdy) begin img[waddr] = wdata; nwr++; end
    if (rst_n && fdrop) nfd++;
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // err_mode: 0 none, 1 error before CRC, 2 error after CRC
  task automatic frame(int n, int seed, int err_mode, bit pre_chk = 0);
    int c0;
    c0 = cnt;
    sof = 1; cyc(); sof = 0; cyc();
    for (int i = 0; i < n; i++) begin
      bvld = 1; bdat = 8'(seed + i); cyc(); bvld = 0; cyc();
      if (i == 1) begin arb = 1; cyc(); arb = 0; end
    end
    if (err_mode == 1) begin err = 1; cyc(); err = 0; end
    crc = 1; cyc(); crc = 0; cyc(6);
    if (err_mode == 2) begin err = 1; cyc(); err = 0; end
    cyc(4);
    if (pre_chk) chk("R2 no commit before eof7", cnt, c0);
    eof7 = 1; cyc(); eof7 = 0; cyc(3);
  endtask

  task automatic chk_slot(string tag, int slot, int n, int seed);
    for (int i = 0; i < n; i++) chk(tag, img[slot * MB + i], (seed + i) & 255);
  endtask

  initial begin
    int w0;
    cyc(3);
    chk("R2 reset count", cnt, 0);
    chk("R6 reset flag", serr, 0);
    chk("R6 reset code", code, 0);
    chk("R1 reset wvalid", wvalid, 0);
    rst_n = 1; cyc(2);

    frame(8, 16, 0, 1);
    chk("R2 count after frame", cnt, 1);
    chk_slot("R1 slot0 bytes", 0, 8, 16);
    frame(5, 64, 0);
    chk("R2 second commit", cnt, 2);
    chk_slot("R1 slot1 bytes", 1, 5, 64);

    pop = 1; cyc(); pop = 0; cyc();
    chk("R10 pop count", cnt, 1);
    chk("R10 pop slot", rslot, 1);

    w0 = nwr;
    frame(6, 100, 1);
    chk("R8 early error writes", nwr, w0);
    chk("R8 early error count", cnt, 1);
    frame(6, 120, 2);
    chk("R8 late error count", cnt, 1);

    rdy = 0; w0 = nwr;
    frame(8, 32, 0);
    frame(7, 200, 0);
    chk("R3 flag after overflow", serr, 1);
    chk("R6 code after overflow", code, 69);
    chk("R3 no writes while stalled", nwr, w0);
    rdy = 1; cyc(20);
    chk("R4 older committed", cnt, 2);
    chk("R3 newer discarded", nwr, w0 + 8);
    chk_slot("R4 older bytes", 2, 8, 32);

    frame(4, 150, 0);
    chk("R5 normal after overflow", cnt, 3);
    chk_slot("R5 bytes", 3, 4, 150);

    swr = 1; swd = 1; cyc(); swr = 0; cyc();
    chk("R7 write one ignored", serr, 1);
    swr = 1; swd = 0; cyc(); swr = 0; cyc();
    chk("R7 write zero clears", serr, 0);
    chk("R7 code cleared", code, 0);

    frame(3, 90, 0);
    chk("R9 fifo full", cnt, 4);
    w0 = nwr;
    frame(3, 180, 0);
    chk("R9 full drop pulse", nfd, 1);
    chk("R9 count stays", cnt, 4);
    chk("R9 writes held", nwr, w0);
    chk("R9 no system error", serr, 0);

    pop = 1; cyc(4); pop = 0; cyc();
    chk("R10 drained", cnt, 0);
    frame(2, 7, 0);
    chk("R5 reuse after drain", cnt, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule